// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steers a microprogrammed control unit through its control store. It holds the microprogram counter, reads the control word at that address from an internal read-only store, and presents the word to the downstream microoperation decoders. It also decides which address comes next. The store's contents are fixed when the block is elaborated, through an image parameter that the integrator supplies.

Each control word carries a 2-bit condition selector, a 2-bit sequencing code and a 7-bit target address. The three microoperation fields above them are passed through to the decoders and are not interpreted here. The condition selector picks either a constant true or one of three processor status flags. The sequencing code then chooses one of four next addresses: the target (jump), the target plus saving the return point (call), the saved return point (return), or a dispatch address formed from the 4-bit machine opcode (map).

A call remembers only one return address, so nested calls overwrite it. The control word output and the counter are plain per-cycle control signals with no handshake. The sequencer advances on every clock that is not in reset.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter and the saved return address to 0. While reset is held, `uword_o` loads the word stored at address 0.
- R2: In every cycle out of reset, `uword_o` holds the control-store word at address `upc_o`. The word layout, from bit 19 down, is: three 3-bit microoperation fields, CD[10:9], BR[8:7] and AD[6:0].
- R3: The condition selector CD works as follows: 00 is always true, 01 tests `status_i[0]`, 10 tests `status_i[1]` and 11 tests `status_i[2]`.
- R4: BR=00 (jump): when the condition holds, the next counter value is AD. Otherwise it is the counter plus one.
- R5: BR=01 (call): a taken call loads AD and saves the counter plus one as the return address. A call that is not taken advances by one and leaves the saved address unchanged.
- R6: BR=10 (return): the next counter value is the saved return address, whatever CD, AD and the status flags hold.
- R7: BR=11 (map): the next counter value is {0, opcode_i[3:0], 00}, whatever CD, AD and the status flags hold. The opcode has no effect under any other BR code.
- R8: Sequential advance wraps from address 127 to address 0. The saved return address of a call made at 127 is 0.
- R9: Only one return address is kept. A call made inside a called routine replaces it, and a later return goes to the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 3 | Processor status flags tested by the condition selector |
| opcode_i | input | 4 | Opcode of the current machine instruction, used by map |
| upc_o | output | 7 | Current microprogram counter |
| uword_o | output | 20 | Control word stored at `upc_o` |

## Verification
A corrupted counter shows up in the next cycle, both as a wrong `upc_o` and as a `uword_o` that belongs to another address. The comparison is made per cycle against a reference walk of the same program. A corrupted saved return address is silent until the next return executes, so the program makes returns right after taken calls, after calls that are not taken, after nested calls and right after reset. A wrong condition tap or wrong map layout shows within one cycle of the word that uses it. Each status flag and several opcodes are therefore driven both ways through the dispatch routine.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int FW      = 3;
  localparam int CDW     = 2;
  localparam int BRW     = 2;
  localparam int ADW     = 7;
  localparam int OPW     = 4;
  localparam int MAP_LO  = 2;
  localparam int MAP_PAD = ADW - OPW - MAP_LO;
  localparam int UW      = 3 * FW + CDW + BRW + ADW;
  localparam int NCOND   = 1 << CDW;
  localparam int STW     = NCOND - 1;
  localparam int DEPTH   = 1 << ADW;

  typedef enum logic [BRW-1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_e;

  typedef struct packed {
    logic [FW-1:0]  f1;
    logic [FW-1:0]  f2;
    logic [FW-1:0]  f3;
    logic [CDW-1:0] cd;
    br_e            br;
    logic [ADW-1:0] ad;
  } uword_t;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter logic [DEPTH*UW-1:0] IMAGE = '0
) (
  input  logic           clk,
  input  logic [ADW-1:0] rd_addr,
  output logic [UW-1:0]  rd_data
);
  // Registered read: the word appears one edge after its address.
  always_ff @(posedge clk) begin
    rd_data <= IMAGE[int'(rd_addr) * UW +: UW];
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [CDW-1:0] cd,
  input  logic [STW-1:0] status,
  output logic           hit
);
  logic [NCOND-1:0] cand;

  // Selector 0 is the constant true; the others tap one status flag each.
  assign cand[0] = 1'b1;
  for (genvar g = 1; g < NCOND; g++) begin : g_tap
    assign cand[g] = status[g-1];
  end

  assign hit = cand[cd];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [ADW-1:0] pc,
  input  uword_t         word,
  input  logic           hit,
  input  logic [OPW-1:0] opcode,
  input  logic [ADW-1:0] ret_addr,
  output logic [ADW-1:0] nxt,
  output logic [ADW-1:0] pc_inc,
  output logic           save
);
  logic [ADW-1:0] map_addr;

  assign pc_inc   = pc + 1'b1;
  assign map_addr = {{MAP_PAD{1'b0}}, opcode, {MAP_LO{1'b0}}};

  always_comb begin
    save = 1'b0;
    unique case (word.br)
      BR_JUMP: nxt = hit ? word.ad : pc_inc;
      BR_CALL: begin
        nxt  = hit ? word.ad : pc_inc;
        save = hit;
      end
      BR_RET:  nxt = ret_addr;
      BR_MAP:  nxt = map_addr;
      default: nxt = pc_inc;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter logic [DEPTH*UW-1:0] IMAGE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [STW-1:0] status_i,
  input  logic [OPW-1:0] opcode_i,
  output logic [ADW-1:0] upc_o,
  output logic [UW-1:0]  uword_o
);
  logic [ADW-1:0] pc_q;
  logic [ADW-1:0] sbr_q;
  logic [ADW-1:0] nxt;
  logic [ADW-1:0] pc_inc;
  logic [ADW-1:0] fetch_addr;
  logic           save;
  logic           hit;
  logic [UW-1:0]  rom_q;
  uword_t         cur;

  assign cur = uword_t'(rom_q);

  useq_cond u_cond (
    .cd     (cur.cd),
    .status (status_i),
    .hit    (hit)
  );

  useq_next u_next (
    .pc       (pc_q),
    .word     (cur),
    .hit      (hit),
    .opcode   (opcode_i),
    .ret_addr (sbr_q),
    .nxt      (nxt),
    .pc_inc   (pc_inc),
    .save     (save)
  );

  // The store is addressed with the next counter value, so its registered
  // output always matches the counter after the same edge.
  assign fetch_addr = rst ? '0 : nxt;

  useq_rom #(.IMAGE(IMAGE)) u_rom (
    .clk     (clk),
    .rd_addr (fetch_addr),
    .rd_data (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      sbr_q <= '0;
    end else begin
      pc_q <= nxt;
      if (save) sbr_q <= pc_inc;
    end
  end

  assign upc_o   = pc_q;
  assign uword_o = rom_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [STW-1:0] status_i,
  input logic [OPW-1:0] opcode_i,
  input logic [ADW-1:0] upc_o,
  input logic [UW-1:0]  uword_o,
  input logic [ADW-1:0] sbr_q
);
  uword_t w;
  logic   hit_c;
  logic   cond_br;

  assign w = uword_t'(uword_o);

  always_comb begin
    case (w.cd)
      2'b00:   hit_c = 1'b1;
      2'b01:   hit_c = status_i[0];
      2'b10:   hit_c = status_i[1];
      default: hit_c = status_i[2];
    endcase
  end

  assign cond_br = (w.br == BR_JUMP) || (w.br == BR_CALL);

  AST_RESET_ORIGIN: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (upc_o == '0 && sbr_q == '0)) else $error("reset origin"); // R1
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst) (cond_br && hit_c) |=> upc_o == $past(w.ad)) else $error("taken target"); // R4
  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst) (cond_br && !hit_c) |=> upc_o == ADW'($past(upc_o) + 1'b1)) else $error("fall through"); // R8
  AST_CALL_SAVES: assert property (@(posedge clk) disable iff (rst) (w.br == BR_CALL && hit_c) |=> sbr_q == ADW'($past(upc_o) + 1'b1)) else $error("call save"); // R5
  AST_SBR_KEPT: assert property (@(posedge clk) disable iff (rst) !(w.br == BR_CALL && hit_c) |=> $stable(sbr_q)) else $error("sbr kept"); // R5
  AST_RETURN_SRC: assert property (@(posedge clk) disable iff (rst) (w.br == BR_RET) |=> upc_o == $past(sbr_q)) else $error("return source"); // R6
  AST_MAP_ADDR: assert property (@(posedge clk) disable iff (rst) (w.br == BR_MAP) |=> upc_o == {{MAP_PAD{1'b0}}, $past(opcode_i), {MAP_LO{1'b0}}}) else $error("map address"); // R7
endmodule

bind useq_sequencer useq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .status_i (status_i),
  .opcode_i (opcode_i),
  .upc_o    (upc_o),
  .uword_o  (uword_o),
  .sbr_q    (sbr_q)
);

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;
  import useq_pkg::*;

  // Control word: {F fields (9), CD (2), BR (2), AD (7)}.
  function automatic logic [UW-1:0] mk(input int a, input logic [1:0] cd,
                                       input logic [1:0] br, input logic [6:0] ad);
    logic [8:0] f;
    f = {2'b00, a[6:0]};
    return {f, cd, br, ad};
  endfunction

  function automatic logic [UW-1:0] prog_word(input int a);
    case (a)
      0:    return mk(a, 2'b01, 2'b11, 7'h55);  // map (CD, AD ignored)
      4:    return mk(a, 2'b01, 2'b00, 7'h40);  // jump if status0
      5:    return mk(a, 2'b00, 2'b00, 7'h00);
      8:    return mk(a, 2'b10, 2'b01, 7'h50);  // call if status1
      9:    return mk(a, 2'b00, 2'b00, 7'h00);
      12:   return mk(a, 2'b01, 2'b10, 7'h33);  // return, CD/AD ignored
      16:   return mk(a, 2'b00, 2'b00, 7'h7E);
      20:   return mk(a, 2'b00, 2'b01, 7'h60);  // unconditional call
      32:   return mk(a, 2'b00, 2'b00, 7'h00);
      60:   return mk(a, 2'b00, 2'b00, 7'h00);
      64:   return mk(a, 2'b00, 2'b00, 7'h00);
      80:   return mk(a, 2'b11, 2'b10, 7'h7F);  // return
      96:   return mk(a, 2'b00, 2'b01, 7'h68);  // nested call
      97:   return mk(a, 2'b00, 2'b00, 7'h00);
      104:  return mk(a, 2'b10, 2'b10, 7'h11);  // return to latest
      126:  return mk(a, 2'b11, 2'b00, 7'h20);  // jump if status2
      127:  return mk(a, 2'b11, 2'b00, 7'h20);  // else wraps to 0
      default: return mk(a, 2'b00, 2'b00, 7'h00);
    endcase
  endfunction

  function automatic logic [DEPTH*UW-1:0] build_image();
    logic [DEPTH*UW-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++) img[a*UW +: UW] = prog_word(a);
    return img;
  endfunction

  localparam logic [DEPTH*UW-1:0] IMG = build_image();

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2:0]     status_i = '0;
  logic [3:0]     opcode_i = '0;
  logic [6:0]     upc_o;
  logic [UW-1:0]  uword_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [6:0] m_pc  = '0;
  logic [6:0] m_sbr = '0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;  // 8 ns period

  useq_sequencer #(.IMAGE(IMG)) uut (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_i),
    .opcode_i (opcode_i),
    .upc_o    (upc_o),
    .uword_o  (uword_o)
  );

  task automatic check(input string tag, input logic [6:0] epc);
    checks++;
    if (upc_o !== epc || uword_o !== prog_word(int'(epc))) begin
      errors++;
      $display("FAIL %s: upc=%h word=%h expected upc=%h word=%h",
               tag, upc_o, uword_o, epc, prog_word(int'(epc)));
    end
  endtask

  // Driver: entered at a falling edge; applies inputs and predicts next step.
  task automatic run(input logic [3:0] op, input logic [2:0] st, input int n);
    for (int i = 0; i < n; i++) begin
      logic [UW-1:0] w;
      logic [1:0] cd, br;
      logic       hit;
      logic [6:0] nx, inc;
      string      tag;
      opcode_i = op;
      status_i = st;
      w   = prog_word(int'(m_pc));
      cd  = w[10:9];
      br  = w[8:7];
      inc = m_pc + 7'd1;
      hit = (cd == 2'b00) ? 1'b1 : st[cd - 2'd1];
      case (br)
        2'b00: begin nx = hit ? w[6:0] : inc;
                     tag = (!hit && m_pc == 7'h7F) ? "R8 R2" : ((cd != 0) ? "R3 R4" : "R4 R2"); end
        2'b01: begin nx = hit ? w[6:0] : inc;
                     tag = (m_pc == 7'h60) ? "R9 R5" : "R5 R3";
                     if (hit) m_sbr = inc; end
        2'b10: begin nx = m_sbr; tag = (m_pc == 7'h68) ? "R9 R6" : "R6 R2"; end
        default: begin nx = {1'b0, op, 2'b00}; tag = "R7 R2"; end
      endcase
      m_pc = nx;
      exp_q.push_back(nx);
      tag_q.push_back(tag);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    check("R1 reset", 7'h00);
    @(negedge clk);
    rst  = 1'b0;
    m_pc = '0;
    m_sbr = '0;
  endtask

  // Monitor: pops one prediction per clock, sampled 2 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    do_reset();
    run(4'd1, 3'b001, 6);   // jump taken on status0
    run(4'd1, 3'b110, 6);   // jump not taken
    run(4'd2, 3'b010, 8);   // call taken, return to 9
    run(4'd2, 3'b101, 6);   // call not taken
    run(4'd3, 3'b111, 4);   // return to saved 9
    run(4'd5, 3'b000, 10);  // nested call
    run(4'd3, 3'b000, 4);   // return to latest saved address
    run(4'd4, 3'b000, 10);  // wrap 127 -> 0
    run(4'd4, 3'b100, 8);   // jump from 126 on status2
    run(4'd15, 3'b011, 6);  // highest opcode
    run(4'd2, 3'b010, 3);   // leave saved address non-zero
    repeat (3) @(negedge clk);
    do_reset();
    run(4'd3, 3'b111, 4);   // R1: return after reset goes to 0
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: run incomplete, expected finish before 200000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule